// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank-State Checker

This block observes the control pins of a double-data-rate SDRAM interface and, at every rising clock edge, turns them into one classified command. The clock-enable value of the previous and current cycle is supplied alongside chip select, the three strobe lines, the bank bits and the address bus. Clock-enable history separates auto refresh from self-refresh entry and separates the two kinds of power-down. A remembered low-power state separates self-refresh exit from power-down exit.

Alongside the decoder, the block keeps an open/closed flag per bank and a countdown per bank for auto-precharge bursts. A rule checker raises a one-cycle error flag when a command arrives in a state where it is not allowed. Cases that raise the flag: mode programming or refresh with a row open; activating an open bank; accessing a closed bank; a new access while a write burst with auto precharge is still running; any real command directly after mode programming. Bank state is updated whether or not the command was legal. The monitor is meant to sit beside a memory controller in simulation or in silicon debug logic.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: Bus state maps to `cmd_o`, registered at the sampling edge. CKE is high in both cycles. CS# high gives deselect (code 1). CS#/RAS#/CAS#/WE# = L/H/H/H gives NOP (code 0). After reset, `cmd_o`=0, `err_o`=0 and `bank_open_o`=0.
- R2: Pins L/L/L/L with CKE high in both cycles decode as mode register set (code 2) when BA0 is low. They decode as extended mode register set (code 3) when BA0 is high.
- R3: Pins L/L/L/H decode as follows. CKE high in both cycles gives auto refresh (code 4). CKE high then low gives self-refresh entry (code 5). CKE low in both cycles gives low-power hold (code 18). CKE low then high after a self-refresh entry gives self-refresh exit (code 6).
- R4: Activate (L/L/H/H) gives code 7 and sets bit BA of `bank_open_o`. BA value 0..3 selects bank bit 0..3.
- R5: Read (L/H/L/H) gives code 8 with A8 low and code 9 with A8 high. Write (L/H/L/L) gives code 10 with A8 low and code 11 with A8 high.
- R6: Precharge (L/L/H/L) with A8 low gives code 13 and clears only bit BA. With A8 high it gives code 14 and clears every bit, whatever BA holds.
- R7: Mode register set, extended mode register set, auto refresh and self-refresh entry raise `err_o` when any bank is open.
- R8: When the command in the previous cycle was code 2 or 3, any command other than NOP, deselect or hold raises `err_o`. The same command one cycle later is legal.
- R9: After a read or write with auto precharge to an open bank, that bank closes BURST_CYC edges later. After a write with auto precharge, any read or write in the next BURST_CYC cycles raises `err_o`.
- R10: Burst stop (L/H/H/L) gives code 12 and never raises `err_o`.
- R11: NOP or deselect with CKE high then low is power-down entry. It gives code 15 when any bank is open and code 16 when all are closed, and leaves `bank_open_o` unchanged. CKE low then high outside self-refresh gives power-down exit (code 17).
- R12: Activate to an open bank, or read/write to a closed bank, raises `err_o` for that cycle only. A CKE high-to-low drop with any other command gives code 19 and raises `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_prev | input | 1 | Clock enable seen in the previous cycle |
| cke_cur | input | 1 | Clock enable seen in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus, A8 is auto-precharge flag |
| cmd_o | output | 5 | Decoded command code |
| err_o | output | 1 | Rule violation for the decoded command |
| bank_open_o | output | 4 | Open flag per bank |

## Verification
The assertions assume that `cke_prev` truly equals the `cke_cur` of the previous cycle. They also assume that a self-refresh entry is followed only by low-power hold cycles until the exit. Under those assumptions, a self-refresh exit always follows an entry or a hold. Every bench scenario drives CKE pairs through one helper that keeps this continuity, and it never issues a command while CKE is low. Illegal commands are issued on purpose. The properties on bank flags hold for them too, because state updates regardless of the error.

// File: rtl/ddr_mon_pkg.sv
// Package: command codes shared by the monitor, its submodules and checker.
package ddr_mon_pkg;
    typedef enum logic [4:0] {
        CMD_NOP   = 5'd0,  CMD_DESEL = 5'd1,  CMD_MRS   = 5'd2,
        CMD_EMRS  = 5'd3,  CMD_AREF  = 5'd4,  CMD_SRE   = 5'd5,
        CMD_SRX   = 5'd6,  CMD_ACT   = 5'd7,  CMD_RD    = 5'd8,
        CMD_RDA   = 5'd9,  CMD_WR    = 5'd10, CMD_WRA   = 5'd11,
        CMD_BST   = 5'd12, CMD_PRE   = 5'd13, CMD_PREA  = 5'd14,
        CMD_APDE  = 5'd15, CMD_PPDE  = 5'd16, CMD_PDX   = 5'd17,
        CMD_HOLD  = 5'd18, CMD_ILL   = 5'd19
    } ddr_cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
// Combinational decoder: maps clock-enable history plus strobe pins to one
// command. Assumes cke_prev equals last cycle's cke_cur.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic     cke_prev,
    input  logic     cke_cur,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     ba0,
    input  logic     ap,
    input  logic     any_open,
    input  logic     in_sref,
    output ddr_cmd_e cmd
);
    logic [2:0] strobes;
    assign strobes = {ras_n, cas_n, we_n};

    // Select the command from CKE transition first, then from strobe pattern.
    always_comb begin
        cmd = CMD_ILL;
        case ({cke_prev, cke_cur})
            2'b11: begin
                if (cs_n) begin
                    cmd = CMD_DESEL;
                end else begin
                    case (strobes)
                        3'b000:  cmd = ba0 ? CMD_EMRS : CMD_MRS;
                        3'b001:  cmd = CMD_AREF;
                        3'b011:  cmd = CMD_ACT;
                        3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
                        3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
                        3'b110:  cmd = CMD_BST;
                        3'b010:  cmd = ap ? CMD_PREA : CMD_PRE;
                        default: cmd = CMD_NOP;
                    endcase
                end
            end
            2'b10: begin
                if (!cs_n && strobes == 3'b001)
                    cmd = CMD_SRE;
                else if (cs_n || strobes == 3'b111)
                    cmd = any_open ? CMD_APDE : CMD_PPDE;
                else
                    cmd = CMD_ILL;
            end
            2'b01:   cmd = in_sref ? CMD_SRX : CMD_PDX;
            default: cmd = CMD_HOLD;
        endcase
    end
endmodule

// File: rtl/ddr_bank_tracker.sv
// Bank state: one open flag and one auto-precharge countdown per bank, plus a
// global countdown that marks an active write burst with auto precharge.
// Assumes commands arrive already decoded; updates regardless of legality.
module ddr_bank_tracker
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BURST_CYC = 2,
    localparam int NUM_BANKS = 1 << BA_W,
    localparam int CNT_W     = $clog2(BURST_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ddr_cmd_e             cmd,
    input  logic [BA_W-1:0]      ba,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 wr_busy
);
    logic [CNT_W-1:0] wr_cnt;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] ap_cnt;
        logic             hit;
        assign hit = (ba == BA_W'(b));

        // Track open flag and pending auto-precharge for bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
                ap_cnt       <= '0;
            end else if (cmd == CMD_PREA || (cmd == CMD_PRE && hit)) begin
                bank_open[b] <= 1'b0;
                ap_cnt       <= '0;
            end else if (cmd == CMD_ACT && hit) begin
                bank_open[b] <= 1'b1;
            end else if ((cmd == CMD_RDA || cmd == CMD_WRA) && hit && bank_open[b]) begin
                ap_cnt <= CNT_W'(BURST_CYC);
            end else if (ap_cnt != '0) begin
                ap_cnt <= ap_cnt - 1'b1;
                if (ap_cnt == CNT_W'(1))
                    bank_open[b] <= 1'b0;
            end
        end
    end

    // Count down the window in which new reads and writes are forbidden.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_cnt <= '0;
        else if (cmd == CMD_WRA)
            wr_cnt <= CNT_W'(BURST_CYC);
        else if (wr_cnt != '0)
            wr_cnt <= wr_cnt - 1'b1;
    end

    assign wr_busy = (wr_cnt != '0);
endmodule

// File: rtl/ddr_rule_check.sv
// Combinational legality check of the decoded command against bank state
// before the current edge. Assumes bank_open and flags are pre-edge values.
module ddr_rule_check
    import ddr_mon_pkg::*;
#(
    parameter int BA_W = 2,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  ddr_cmd_e             cmd,
    input  logic [BA_W-1:0]      ba,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 wr_busy,
    input  logic                 mode_last,
    output logic                 illegal
);
    logic any_open, sel_open, quiet;
    assign any_open = |bank_open;
    assign sel_open = bank_open[ba];
    assign quiet    = (cmd == CMD_NOP) || (cmd == CMD_DESEL) || (cmd == CMD_HOLD);

    // Combine state-dependent rules into a single violation flag.
    always_comb begin
        illegal = 1'b0;
        case (cmd)
            CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SRE: illegal = any_open;
            CMD_ACT:                              illegal = sel_open;
            CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:     illegal = !sel_open || wr_busy;
            CMD_ILL:                              illegal = 1'b1;
            default:                              illegal = 1'b0;
        endcase
        if (mode_last && !quiet)
            illegal = 1'b1;
    end
endmodule

// File: rtl/ddr_cmd_monitor.sv
// Top: decodes the DDR SDRAM control bus every edge, tracks bank state and
// flags rule violations. Outputs are registered at the sampling edge.
// Assumes cke_prev is the previous cycle's cke_cur.
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 8,
    parameter int BA_W      = 2,
    parameter int BURST_CYC = 2,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_prev,
    input  logic                 cke_cur,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [4:0]           cmd_o,
    output logic                 err_o,
    output logic [NUM_BANKS-1:0] bank_open_o
);
    ddr_cmd_e             cmd_now;
    logic [NUM_BANKS-1:0] bank_open;
    logic                 wr_busy, illegal, in_sref, mode_last;

    ddr_cmd_decode u_decode (
        .cke_prev (cke_prev), .cke_cur (cke_cur),
        .cs_n     (cs_n),     .ras_n   (ras_n),
        .cas_n    (cas_n),    .we_n    (we_n),
        .ba0      (ba[0]),    .ap      (addr[AP_BIT]),
        .any_open (|bank_open), .in_sref (in_sref),
        .cmd      (cmd_now)
    );

    ddr_bank_tracker #(.BA_W(BA_W), .BURST_CYC(BURST_CYC)) u_banks (
        .clk (clk), .rst_n (rst_n), .cmd (cmd_now), .ba (ba),
        .bank_open (bank_open), .wr_busy (wr_busy)
    );

    ddr_rule_check #(.BA_W(BA_W)) u_rules (
        .cmd (cmd_now), .ba (ba), .bank_open (bank_open),
        .wr_busy (wr_busy), .mode_last (mode_last), .illegal (illegal)
    );

    // Remember self-refresh residency and whether mode programming just happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sref   <= 1'b0;
            mode_last <= 1'b0;
        end else begin
            if (cmd_now == CMD_SRE)
                in_sref <= 1'b1;
            else if (cmd_now == CMD_SRX || cmd_now == CMD_PDX)
                in_sref <= 1'b0;
            mode_last <= (cmd_now == CMD_MRS) || (cmd_now == CMD_EMRS);
        end
    end

    // Register the decoded command and its violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= 5'd0;
            err_o <= 1'b0;
        end else begin
            cmd_o <= cmd_now;
            err_o <= illegal;
        end
    end

    assign bank_open_o = bank_open;
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
// Checker: temporal properties over the monitor's outputs. Bound to the top.
module ddr_cmd_monitor_chk
    import ddr_mon_pkg::*;
#(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [4:0]    cmd_o,
    input logic          err_o,
    input logic [NB-1:0] bank_open_o
);
    assert_prea_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_PREA |-> bank_open_o == '0);

    assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_ACT |-> bank_open_o != '0);

    assert_mode_open_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_MRS || cmd_o == CMD_EMRS || cmd_o == CMD_AREF || cmd_o == CMD_SRE)
        && bank_open_o != '0 |-> err_o);

    assert_after_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_o) == CMD_MRS || $past(cmd_o) == CMD_EMRS)
        && !(cmd_o == CMD_NOP || cmd_o == CMD_DESEL || cmd_o == CMD_HOLD) |-> err_o);

    assert_ppd_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_PPDE |-> bank_open_o == '0);

    assert_apd_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_APDE |-> bank_open_o != '0);

    assert_bst_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_BST && $past(cmd_o) != CMD_MRS && $past(cmd_o) != CMD_EMRS |-> !err_o);

    assert_srx_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_SRX |-> ($past(cmd_o) == CMD_SRE || $past(cmd_o) == CMD_HOLD));
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.NB(NUM_BANKS)) u_chk (
    .clk (clk), .rst_n (rst_n), .cmd_o (cmd_o),
    .err_o (err_o), .bank_open_o (bank_open_o)
);

// File: tb/ddr_cmd_monitor_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module ddr_cmd_monitor_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] P_MRS = 4'b0000, P_REF = 4'b0001, P_ACT = 4'b0011,
                           P_RD  = 4'b0101, P_WR  = 4'b0100, P_BST = 4'b0110,
                           P_PRE = 4'b0010, P_NOP = 4'b0111, P_DES = 4'b1111;
    localparam logic [11:0] A_AP = 12'h100, A_NO = 12'h023;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke_prev = 1'b1, cke_cur = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [11:0] addr = '0;
    logic [4:0] cmd_o;
    logic err_o;
    logic [3:0] bank_open_o;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_cmd_monitor dut_i (
        .clk (clk), .rst_n (rst_n), .cke_prev (cke_prev), .cke_cur (cke_cur),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .cmd_o (cmd_o), .err_o (err_o),
        .bank_open_o (bank_open_o)
    );

    task automatic step(input logic cke, input logic [3:0] pins,
                        input logic [1:0] b, input logic [11:0] a);
        @(negedge clk);
        cke_prev = cke_cur;
        cke_cur  = cke;
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba = b;
        addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [4:0] ec,
                       input logic ee, input logic [3:0] eo);
        checks++;
        if (cmd_o !== ec || err_o !== ee || bank_open_o !== eo) begin
            errors++;
            $display("FAIL %s: cmd=%0d err=%0b open=%b expected cmd=%0d err=%0b open=%b",
                     req, cmd_o, err_o, bank_open_o, ec, ee, eo);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset", 5'd0, 1'b0, 4'b0000);
    endtask

    task automatic t_nop();
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R1 nop", 5'd0, 1'b0, 4'b0000);
        step(1'b1, P_DES, 2'd3, A_AP); chk("R1 deselect", 5'd1, 1'b0, 4'b0000);
    endtask

    task automatic t_mode();
        step(1'b1, P_MRS, 2'd0, A_NO); chk("R2 mrs", 5'd2, 1'b0, 4'b0000);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R8 nop after mrs", 5'd0, 1'b0, 4'b0000);
        step(1'b1, P_MRS, 2'd1, A_NO); chk("R2 emrs", 5'd3, 1'b0, 4'b0000);
        step(1'b1, P_ACT, 2'd0, A_NO); chk("R8 act right after emrs", 5'd7, 1'b1, 4'b0001);
        step(1'b1, P_PRE, 2'd2, A_AP); chk("R6 prea", 5'd14, 1'b0, 4'b0000);
        step(1'b1, P_MRS, 2'd0, A_NO); chk("R2 mrs again", 5'd2, 1'b0, 4'b0000);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R8 gap", 5'd0, 1'b0, 4'b0000);
        step(1'b1, P_ACT, 2'd0, A_NO); chk("R8 act one cycle later", 5'd7, 1'b0, 4'b0001);
        step(1'b1, P_MRS, 2'd0, A_NO); chk("R7 mrs with open bank", 5'd2, 1'b1, 4'b0001);
        step(1'b1, P_PRE, 2'd1, A_AP); chk("R6 prea ignores ba", 5'd14, 1'b1, 4'b0000);
    endtask

    task automatic t_banks();
        step(1'b1, P_ACT, 2'd2, A_NO); chk("R4 act bank2", 5'd7, 1'b0, 4'b0100);
        step(1'b1, P_ACT, 2'd1, A_NO); chk("R4 act bank1", 5'd7, 1'b0, 4'b0110);
        step(1'b1, P_ACT, 2'd1, A_NO); chk("R12 act open bank", 5'd7, 1'b1, 4'b0110);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R12 error one cycle", 5'd0, 1'b0, 4'b0110);
        step(1'b1, P_RD,  2'd3, A_NO); chk("R12 read closed bank", 5'd8, 1'b1, 4'b0110);
        step(1'b1, P_PRE, 2'd2, A_NO); chk("R6 pre bank2 only", 5'd13, 1'b0, 4'b0010);
        step(1'b1, P_PRE, 2'd0, A_AP); chk("R6 prea all", 5'd14, 1'b0, 4'b0000);
    endtask

    task automatic t_rw();
        step(1'b1, P_ACT, 2'd0, A_NO); chk("R4 act bank0", 5'd7, 1'b0, 4'b0001);
        step(1'b1, P_RD,  2'd0, A_NO); chk("R5 read", 5'd8, 1'b0, 4'b0001);
        step(1'b1, P_WR,  2'd0, A_NO); chk("R5 write", 5'd10, 1'b0, 4'b0001);
        step(1'b1, P_BST, 2'd0, A_NO); chk("R10 burst stop", 5'd12, 1'b0, 4'b0001);
        step(1'b1, P_WR,  2'd0, A_AP); chk("R5 write ap", 5'd11, 1'b0, 4'b0001);
        step(1'b1, P_RD,  2'd0, A_NO); chk("R9 read during wr ap burst", 5'd8, 1'b1, 4'b0001);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R9 bank closes at burst end", 5'd0, 1'b0, 4'b0000);
        step(1'b1, P_ACT, 2'd1, A_NO); chk("R4 act bank1", 5'd7, 1'b0, 4'b0010);
        step(1'b1, P_ACT, 2'd2, A_NO); chk("R4 act bank2", 5'd7, 1'b0, 4'b0110);
        step(1'b1, P_WR,  2'd1, A_AP); chk("R5 write ap bank1", 5'd11, 1'b0, 4'b0110);
        step(1'b1, P_WR,  2'd2, A_NO); chk("R9 other bank write blocked", 5'd10, 1'b1, 4'b0110);
        step(1'b1, P_BST, 2'd0, A_NO); chk("R9 bank1 closed, R10 bst", 5'd12, 1'b0, 4'b0100);
        step(1'b1, P_WR,  2'd2, A_NO); chk("R9 write allowed after burst", 5'd10, 1'b0, 4'b0100);
        step(1'b1, P_RD,  2'd2, A_AP); chk("R5 read ap", 5'd9, 1'b0, 4'b0100);
        step(1'b1, P_RD,  2'd2, A_NO); chk("R9 read ap no write block", 5'd8, 1'b0, 4'b0100);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R9 read ap closes bank", 5'd0, 1'b0, 4'b0000);
    endtask

    task automatic t_refresh();
        step(1'b1, P_REF, 2'd0, A_NO); chk("R3 auto refresh", 5'd4, 1'b0, 4'b0000);
        step(1'b1, P_ACT, 2'd3, A_NO); chk("R4 act bank3", 5'd7, 1'b0, 4'b1000);
        step(1'b1, P_REF, 2'd0, A_NO); chk("R7 refresh with open bank", 5'd4, 1'b1, 4'b1000);
        step(1'b1, P_PRE, 2'd3, A_NO); chk("R6 pre bank3", 5'd13, 1'b0, 4'b0000);
        step(1'b0, P_REF, 2'd0, A_NO); chk("R3 self refresh entry", 5'd5, 1'b0, 4'b0000);
        step(1'b0, P_DES, 2'd0, A_NO); chk("R3 hold", 5'd18, 1'b0, 4'b0000);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R3 self refresh exit", 5'd6, 1'b0, 4'b0000);
    endtask

    task automatic t_powerdown();
        step(1'b0, P_NOP, 2'd0, A_NO); chk("R11 precharge pd entry", 5'd16, 1'b0, 4'b0000);
        step(1'b0, P_DES, 2'd0, A_NO); chk("R11 pd hold", 5'd18, 1'b0, 4'b0000);
        step(1'b1, P_DES, 2'd0, A_NO); chk("R11 pd exit", 5'd17, 1'b0, 4'b0000);
        step(1'b1, P_ACT, 2'd0, A_NO); chk("R4 act bank0", 5'd7, 1'b0, 4'b0001);
        step(1'b0, P_DES, 2'd0, A_NO); chk("R11 active pd entry", 5'd15, 1'b0, 4'b0001);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R11 active pd exit", 5'd17, 1'b0, 4'b0001);
        step(1'b0, P_RD,  2'd0, A_NO); chk("R12 cke drop with read", 5'd19, 1'b1, 4'b0001);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R11 exit after illegal drop", 5'd17, 1'b0, 4'b0001);
        step(1'b0, P_REF, 2'd0, A_NO); chk("R7 self refresh with open bank", 5'd5, 1'b1, 4'b0001);
        step(1'b1, P_NOP, 2'd0, A_NO); chk("R3 self refresh exit", 5'd6, 1'b0, 4'b0001);
        step(1'b1, P_PRE, 2'd0, A_AP); chk("R6 prea", 5'd14, 1'b0, 4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_nop();
        t_mode();
        t_banks();
        t_rw();
        t_refresh();
        t_powerdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule